// File: doc/BRIEF.md
# Eight-Channel Block DMA Controller

This block moves data elements between a byte-addressed dual-port buffer RAM and a space of peripheral registers. Eight channels share one transfer engine. Each channel is set up through a small register bus with these settings: a direction, an element size, an addressing mode, two buffer start addresses, an element count, a peripheral register address and a request-source select. Once set up, a channel waits for requests and moves one element per request.

Either a software trigger write or a selected hardware request line can start an element transfer. When several channels have a pending request, a fixed-priority arbiter picks one. The engine reads the source in one cycle and writes the destination in the next cycle. Arbitration runs again before every element. A block ends after a programmed number of elements. The channel then either disables itself, restarts at its base address, or restarts at the other of its two base addresses. It pulses an interrupt either at the end of the block or at the half-way point.

Top module: `dma_blk`

## Requirements
- R1: Register address is {channel[2:0], register[2:0]}. The registers are: 0 control, 1 buffer start A, 2 buffer start B, 3 count, 4 peripheral address, 5 request select, 6 status, 7 trigger. Registers 1 to 5 read back what was written. Control reads back bit0 enable, bit1 direction, bit2 byte size, bits4:3 address mode, bits6:5 block mode and bit7 half-interrupt select. Writing control restarts the block at buffer A. After reset every register reads 0 and every output strobe is low.
- R2: Direction bit 0 copies peripheral to RAM and direction bit 1 copies RAM to peripheral. Each element takes one read cycle on the source port, then one write cycle on the destination port carrying the read data. No cycle has more than one port strobe active.
- R3: Address mode 0 (post-increment) places element k of a block at base + k for byte size or base + 2k for word size.
- R4: Address mode 1 (fixed) places every element of a block at the base address.
- R5: Address mode 2 (peripheral-supplied) uses per_bufaddr_i, sampled when the element is granted, as the RAM address.
- R6: Word elements use both RAM byte lanes. A byte element uses lane 0 at an even address and lane 1 at an odd address. On the peripheral side a byte element is the low 8 bits, and a read from RAM is zero-extended.
- R7: Channel 0 has the highest priority and channel 7 the lowest. Arbitration is repeated for every element, and only one channel is granted at a time.
- R8: A write to the trigger register, or a high level on req_src_i[select] in any cycle, is one request. Requests to a disabled channel, and levels on sources the channel has not selected, have no effect.
- R9: Block mode 0 (one-shot): after count+1 elements the channel clears its enable bit and pulses its interrupt. It then ignores further requests.
- R10: Block mode 1 (auto-repeat): after count+1 elements the channel pulses its interrupt, stays enabled and starts the next block at the same base.
- R11: Block mode 2 (ping-pong): blocks alternate between start A and start B, beginning with A. Status bit1 reads 1 while start B is in use.
- R12: With the half-interrupt bit set, the interrupt pulses once after floor((count+1)/2) elements of each block and not at the end of the block. When count is 0 there is no half-way pulse.
- R13: A request that arrives while the channel already has a pending request that is not being granted in that cycle sets status bit0 (collision), and the extra request is dropped. Writing 1 to status bit0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 6 | Register address {channel, register} |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| req_src_i | input | 16 | Hardware request sources |
| irq_o | output | 8 | Per-channel interrupt pulses |
| ram_addr_o | output | 12 | Buffer RAM byte address |
| ram_be_o | output | 2 | Buffer RAM byte enables |
| ram_re_o | output | 1 | Buffer RAM read strobe (data next cycle) |
| ram_we_o | output | 1 | Buffer RAM write strobe |
| ram_wdata_o | output | 16 | Buffer RAM write data |
| ram_rdata_i | input | 16 | Buffer RAM read data |
| per_addr_o | output | 8 | Peripheral register address |
| per_re_o | output | 1 | Peripheral read strobe (data next cycle) |
| per_we_o | output | 1 | Peripheral write strobe |
| per_wdata_o | output | 16 | Peripheral write data |
| per_rdata_i | input | 16 | Peripheral read data |
| per_bufaddr_i | input | 12 | RAM address supplied by the peripheral |

## Verification
The bench sweeps every channel in both element sizes through a one-shot block. It checks that the fifth request leaves the word after the block untouched; a design with an off-by-one block length would write that word or stop one element early. Odd-address byte reads and the element ordering in ping-pong mode are checked against values computed in the bench. A wrong byte lane or a missed buffer swap shows up as a wrong data word. Three channels are made to request in the same cycle and the order of the peripheral writes is checked, which exposes an inverted priority. A half-interrupt block of five elements is followed for two blocks, which catches a pulse on the wrong element or an extra pulse at the block end. A request line held high against a busy channel must set the collision flag exactly when a second request finds one still pending.

// File: rtl/dma_blk_pkg.sv
package dma_blk_pkg;
  localparam int RW = 16;

  localparam logic [2:0] REG_CTL  = 3'd0;
  localparam logic [2:0] REG_STA  = 3'd1;
  localparam logic [2:0] REG_STB  = 3'd2;
  localparam logic [2:0] REG_CNT  = 3'd3;
  localparam logic [2:0] REG_PAD  = 3'd4;
  localparam logic [2:0] REG_SEL  = 3'd5;
  localparam logic [2:0] REG_STAT = 3'd6;
  localparam logic [2:0] REG_TRIG = 3'd7;

  localparam logic [1:0] AM_INC  = 2'd0;
  localparam logic [1:0] AM_FIX  = 2'd1;
  localparam logic [1:0] AM_PIND = 2'd2;

  localparam logic [1:0] BM_ONE  = 2'd0;
  localparam logic [1:0] BM_REP  = 2'd1;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} xfer_st_e;
endpackage

// File: rtl/dma_arb.sv
module dma_arb #(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         en_i,
  output logic [N-1:0] gnt_o
);
  // lowest index wins
  assign gnt_o = en_i ? (req_i & (~req_i + N'(1))) : '0;

  AST_GNT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o)); // R7
  AST_GNT_IN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0)); // R7
  AST_GNT_WHEN_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && req_i != '0) |-> (gnt_o != '0)); // R7
endmodule

// File: rtl/dma_chan.sv
module dma_chan
  import dma_blk_pkg::*;
#(
  parameter int AW   = 12,
  parameter int PAW  = 8,
  parameter int CW   = 10,
  parameter int NSRC = 16,
  localparam int SW  = $clog2(NSRC)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [2:0]      reg_i,
  input  logic [RW-1:0]   wdata_i,
  input  logic [NSRC-1:0] src_i,
  input  logic            start_i,
  input  logic            done_i,
  output logic            pend_o,
  output logic            dir_o,
  output logic            byte_o,
  output logic            pind_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [PAW-1:0]  per_addr_o,
  output logic [RW-1:0]   rdata_o,
  output logic            irq_o
);
  logic            en_q, dir_q, byt_q, half_q, coll_q, pp_q, pend_q, irq_q;
  logic [1:0]      am_q, bm_q;
  logic [AW-1:0]   sta_q, stb_q, off_q;
  logic [CW-1:0]   cnt_q, idx_q;
  logic [PAW-1:0]  pad_q;
  logic [SW-1:0]   sel_q;
  logic            ctl_wr, req, last;
  logic [CW:0]     half_pt;
  logic [AW-1:0]   step;

  assign ctl_wr  = wr_i && reg_i == REG_CTL;
  assign req     = en_q && (src_i[sel_q] || (wr_i && reg_i == REG_TRIG));
  assign last    = idx_q == cnt_q;
  assign half_pt = ({1'b0, cnt_q} + 1'b1) >> 1;
  assign step    = byt_q ? AW'(1) : AW'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; dir_q <= 1'b0; byt_q <= 1'b0; half_q <= 1'b0;
      coll_q <= 1'b0; pp_q <= 1'b0; pend_q <= 1'b0; irq_q <= 1'b0;
      am_q <= '0; bm_q <= '0; sta_q <= '0; stb_q <= '0; off_q <= '0;
      cnt_q <= '0; idx_q <= '0; pad_q <= '0; sel_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (done_i && !ctl_wr) begin
        if (half_q && ({1'b0, idx_q} + 1'b1) == half_pt) irq_q <= 1'b1;
        if (last) begin
          idx_q <= '0;
          off_q <= '0;
          if (!half_q) irq_q <= 1'b1;
          if (bm_q == BM_ONE) en_q <= 1'b0;
          if (bm_q[1]) pp_q <= ~pp_q;
        end else begin
          idx_q <= idx_q + 1'b1;
          if (am_q == AM_INC) off_q <= off_q + step;
        end
      end
      if (wr_i) begin
        case (reg_i)
          REG_CTL: begin
            en_q <= wdata_i[0]; dir_q <= wdata_i[1]; byt_q <= wdata_i[2];
            am_q <= wdata_i[4:3]; bm_q <= wdata_i[6:5]; half_q <= wdata_i[7];
            idx_q <= '0; off_q <= '0; pp_q <= 1'b0;
          end
          REG_STA:  sta_q <= wdata_i[AW-1:0];
          REG_STB:  stb_q <= wdata_i[AW-1:0];
          REG_CNT:  cnt_q <= wdata_i[CW-1:0];
          REG_PAD:  pad_q <= wdata_i[PAW-1:0];
          REG_SEL:  sel_q <= wdata_i[SW-1:0];
          REG_STAT: if (wdata_i[0]) coll_q <= 1'b0;
          default: ;
        endcase
      end
      if (req && pend_q && !start_i) coll_q <= 1'b1;
      if (req) pend_q <= 1'b1;
      else if (start_i) pend_q <= 1'b0;
      if (ctl_wr && !wdata_i[0]) pend_q <= 1'b0;
    end
  end

  assign pend_o     = pend_q;
  assign dir_o      = dir_q;
  assign byte_o     = byt_q;
  assign pind_o     = am_q == AM_PIND;
  assign ram_addr_o = (pp_q ? stb_q : sta_q) + off_q;
  assign per_addr_o = pad_q;
  assign irq_o      = irq_q;

  always_comb begin
    case (reg_i)
      REG_CTL:  rdata_o = {8'd0, half_q, bm_q, am_q, byt_q, dir_q, en_q};
      REG_STA:  rdata_o = RW'(sta_q);
      REG_STB:  rdata_o = RW'(stb_q);
      REG_CNT:  rdata_o = RW'(cnt_q);
      REG_PAD:  rdata_o = RW'(pad_q);
      REG_SEL:  rdata_o = RW'(sel_q);
      REG_STAT: rdata_o = {14'd0, pp_q, coll_q};
      default:  rdata_o = '0;
    endcase
  end

  AST_START_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> pend_q); // R7
  AST_ONESHOT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && last && bm_q == BM_ONE && !ctl_wr) |=> !en_q); // R9
  AST_HALF_NO_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && last && half_q && !ctl_wr) |=> !irq_q); // R12
  AST_COLLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && pend_q && !start_i) |=> coll_q); // R13
endmodule

// File: rtl/dma_xfer.sv
module dma_xfer
  import dma_blk_pkg::*;
#(
  parameter int N   = 8,
  parameter int AW  = 12,
  parameter int PAW = 8,
  localparam int CHW = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N-1:0]            gnt_i,
  input  logic [N-1:0]            dir_i,
  input  logic [N-1:0]            byte_i,
  input  logic [N-1:0]            pind_i,
  input  logic [N-1:0][AW-1:0]    ram_addr_i,
  input  logic [N-1:0][PAW-1:0]   per_addr_i,
  input  logic [AW-1:0]           bufaddr_i,
  output logic                    idle_o,
  output logic [N-1:0]            start_o,
  output logic [N-1:0]            done_o,
  output logic [AW-1:0]           ram_addr_o,
  output logic [1:0]              ram_be_o,
  output logic                    ram_re_o,
  output logic                    ram_we_o,
  output logic [RW-1:0]           ram_wdata_o,
  input  logic [RW-1:0]           ram_rdata_i,
  output logic [PAW-1:0]          per_addr_o,
  output logic                    per_re_o,
  output logic                    per_we_o,
  output logic [RW-1:0]           per_wdata_o,
  input  logic [RW-1:0]           per_rdata_i
);
  xfer_st_e       st_q;
  logic [CHW-1:0] gidx, ch_q;
  logic           dir_q, byt_q;
  logic [AW-1:0]  ram_q;
  logic [PAW-1:0] per_q;
  logic [7:0]     lane;

  always_comb begin
    gidx = '0;
    for (int i = N - 1; i >= 0; i--) if (gnt_i[i]) gidx = CHW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; ch_q <= '0; dir_q <= 1'b0; byt_q <= 1'b0;
      ram_q <= '0; per_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (gnt_i != '0) begin
          st_q  <= ST_RD;
          ch_q  <= gidx;
          dir_q <= dir_i[gidx];
          byt_q <= byte_i[gidx];
          ram_q <= pind_i[gidx] ? bufaddr_i : ram_addr_i[gidx];
          per_q <= per_addr_i[gidx];
        end
        ST_RD:   st_q <= ST_WR;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o  = st_q == ST_IDLE;
  assign start_o = idle_o ? gnt_i : '0;
  assign done_o  = (st_q == ST_WR) ? (N'(1) << ch_q) : '0;

  assign ram_addr_o  = ram_q;
  assign per_addr_o  = per_q;
  assign ram_re_o    = st_q == ST_RD && dir_q;
  assign per_re_o    = st_q == ST_RD && !dir_q;
  assign ram_we_o    = st_q == ST_WR && !dir_q;
  assign per_we_o    = st_q == ST_WR && dir_q;
  assign ram_be_o    = !byt_q ? 2'b11 : (ram_q[0] ? 2'b10 : 2'b01);
  assign ram_wdata_o = byt_q ? {2{per_rdata_i[7:0]}} : per_rdata_i;
  assign lane        = ram_q[0] ? ram_rdata_i[15:8] : ram_rdata_i[7:0];
  assign per_wdata_o = byt_q ? {8'd0, lane} : ram_rdata_i;

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ram_re_o, ram_we_o, per_re_o, per_we_o}) <= 1); // R2
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_we_o || per_we_o) |-> $past(ram_re_o || per_re_o)); // R2
  AST_DONE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(done_o)); // R7
endmodule

// File: rtl/dma_blk.sv
module dma_blk
  import dma_blk_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int AW   = 12,
  parameter int PAW  = 8,
  parameter int CW   = 10,
  parameter int NSRC = 16,
  localparam int CHW = $clog2(N_CH),
  localparam int RAW = CHW + 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            reg_we_i,
  input  logic [RAW-1:0]  reg_addr_i,
  input  logic [RW-1:0]   reg_wdata_i,
  output logic [RW-1:0]   reg_rdata_o,
  input  logic [NSRC-1:0] req_src_i,
  output logic [N_CH-1:0] irq_o,
  output logic [AW-1:0]   ram_addr_o,
  output logic [1:0]      ram_be_o,
  output logic            ram_re_o,
  output logic            ram_we_o,
  output logic [RW-1:0]   ram_wdata_o,
  input  logic [RW-1:0]   ram_rdata_i,
  output logic [PAW-1:0]  per_addr_o,
  output logic            per_re_o,
  output logic            per_we_o,
  output logic [RW-1:0]   per_wdata_o,
  input  logic [RW-1:0]   per_rdata_i,
  input  logic [AW-1:0]   per_bufaddr_i
);
  logic [N_CH-1:0]           pend, dir, byt, pind, gnt, start, done;
  logic [N_CH-1:0][AW-1:0]   ch_ram;
  logic [N_CH-1:0][PAW-1:0]  ch_per;
  logic [N_CH-1:0][RW-1:0]   ch_rdata;
  logic                      idle;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    dma_chan #(.AW(AW), .PAW(PAW), .CW(CW), .NSRC(NSRC)) u_chan (
      .clk_i, .rst_ni,
      .wr_i      (reg_we_i && reg_addr_i[RAW-1:3] == CHW'(g)),
      .reg_i     (reg_addr_i[2:0]),
      .wdata_i   (reg_wdata_i),
      .src_i     (req_src_i),
      .start_i   (start[g]),
      .done_i    (done[g]),
      .pend_o    (pend[g]),
      .dir_o     (dir[g]),
      .byte_o    (byt[g]),
      .pind_o    (pind[g]),
      .ram_addr_o(ch_ram[g]),
      .per_addr_o(ch_per[g]),
      .rdata_o   (ch_rdata[g]),
      .irq_o     (irq_o[g])
    );
  end

  assign reg_rdata_o = ch_rdata[reg_addr_i[RAW-1:3]];

  dma_arb #(.N(N_CH)) u_arb (
    .clk_i, .rst_ni, .req_i(pend), .en_i(idle), .gnt_o(gnt)
  );

  dma_xfer #(.N(N_CH), .AW(AW), .PAW(PAW)) u_xfer (
    .clk_i, .rst_ni,
    .gnt_i(gnt), .dir_i(dir), .byte_i(byt), .pind_i(pind),
    .ram_addr_i(ch_ram), .per_addr_i(ch_per), .bufaddr_i(per_bufaddr_i),
    .idle_o(idle), .start_o(start), .done_o(done),
    .ram_addr_o, .ram_be_o, .ram_re_o, .ram_we_o, .ram_wdata_o, .ram_rdata_i,
    .per_addr_o, .per_re_o, .per_we_o, .per_wdata_o, .per_rdata_i
  );

  AST_IRQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ($past(done) == irq_o)); // R9
endmodule

// File: tb/dma_blk_bench.sv
module dma_blk_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [5:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [15:0] req_src_i = '0;
  logic [7:0]  irq_o;
  logic [11:0] ram_addr_o;
  logic [1:0]  ram_be_o;
  logic        ram_re_o, ram_we_o, per_re_o, per_we_o;
  logic [15:0] ram_wdata_o, per_wdata_o;
  logic [15:0] ram_rdata_i = '0, per_rdata_i = '0;
  logic [7:0]  per_addr_o;
  logic [11:0] per_bufaddr_i = '0;

  always #10 clk_i = ~clk_i;

  dma_blk u_dma_blk (.*);

  logic [15:0] ram [0:2047];
  logic [15:0] pm  [0:255];
  logic [7:0]  plog_a [0:63];
  logic [15:0] plog_d [0:63];
  int plog_n = 0;
  int irq_cnt [0:7];
  int n_chk = 0, n_fail = 0;

  always @(posedge clk_i) begin
    if (ram_re_o) ram_rdata_i <= ram[ram_addr_o[11:1]];
    if (ram_we_o) begin
      if (ram_be_o[0]) ram[ram_addr_o[11:1]][7:0]  <= ram_wdata_o[7:0];
      if (ram_be_o[1]) ram[ram_addr_o[11:1]][15:8] <= ram_wdata_o[15:8];
    end
    if (per_re_o) per_rdata_i <= pm[per_addr_o];
    if (per_we_o) begin
      pm[per_addr_o] <= per_wdata_o;
      plog_a[plog_n % 64] <= per_addr_o;
      plog_d[plog_n % 64] <= per_wdata_o;
      plog_n <= plog_n + 1;
    end
    if (rst_ni) for (int i = 0; i < 8; i++) if (irq_o[i]) irq_cnt[i] = irq_cnt[i] + 1;
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int r, input logic [15:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = 6'(ch * 8 + r); reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input int ch, input int r, output logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = 6'(ch * 8 + r);
    #1 d = reg_rdata_o;
  endtask

  task automatic trig(input int ch);
    wr(ch, 7, 16'h0);
    repeat (6) @(negedge clk_i);
  endtask

  task automatic pulse(input int s, input int cyc);
    @(negedge clk_i);
    req_src_i[s] = 1'b1;
    repeat (cyc) @(negedge clk_i);
    req_src_i = '0;
    repeat (15) @(negedge clk_i);
  endtask

  task automatic cfg(input int ch, input logic [15:0] ctl, input logic [11:0] sa,
                     input logic [11:0] sb, input logic [9:0] cnt,
                     input logic [7:0] pad, input logic [3:0] sel);
    wr(ch, 1, 16'(sa)); wr(ch, 2, 16'(sb)); wr(ch, 3, 16'(cnt));
    wr(ch, 4, 16'(pad)); wr(ch, 5, 16'(sel)); wr(ch, 0, ctl);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d, v;
    int i0, p0;
    logic [11:0] base;
    for (int i = 0; i < 8; i++) irq_cnt[i] = 0;
    for (int i = 0; i < 2048; i++) ram[i] = 16'hFFFF;
    for (int i = 0; i < 256; i++) pm[i] = '0;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 reset irq", 32'(irq_o), 0);
    chk("R1 reset strobes", 32'({ram_we_o, ram_re_o, per_we_o, per_re_o}), 0);
    rd(0, 0, d); chk("R1 reset ctl", 32'(d), 0);
    rst_ni = 1'b1;

    // R1 readback
    cfg(5, 16'h00B4, 12'hABC, 12'h123, 10'h2A5, 8'h9E, 4'd11);
    rd(5, 0, d); chk("R1 ctl", 32'(d), 32'h00B4);
    rd(5, 1, d); chk("R1 sta", 32'(d), 32'hABC);
    rd(5, 2, d); chk("R1 stb", 32'(d), 32'h123);
    rd(5, 3, d); chk("R1 cnt", 32'(d), 32'h2A5);
    rd(5, 4, d); chk("R1 pad", 32'(d), 32'h9E);
    rd(5, 5, d); chk("R1 sel", 32'(d), 32'd11);
    wr(5, 0, 16'h0);

    // R2 R3 R6 R8 R9 sweep: every channel, word and byte, one-shot, periph->RAM
    for (int c = 0; c < 8; c++) begin
      for (int b = 0; b < 2; b++) begin
        base = 12'h100 + 12'(c * 64) + 12'(b * 32);
        v = 16'hA5C0 + 16'(c * 2 + b);
        pm[8'h80 + c] = v;
        i0 = irq_cnt[c];
        cfg(c, 16'h0001 | 16'(b << 2), base, 12'h0, 10'd3, 8'(8'h80 + c), 4'd15);
        for (int k = 0; k < 4; k++) trig(c);
        chk("R9 one irq per block", 32'(irq_cnt[c] - i0), 1);
        rd(c, 0, d); chk("R9 enable cleared", 32'(d[0]), 0);
        trig(c);
        for (int k = 0; k < 5; k++) begin
          if (b == 0) begin
            chk("R3 word element", 32'(ram[base[11:1] + 11'(k)]),
                (k < 4) ? 32'(v) : 32'hFFFF);
          end else begin
            logic [11:0] a;
            a = base + 12'(k);
            chk("R6 byte element", 32'(a[0] ? ram[a[11:1]][15:8] : ram[a[11:1]][7:0]),
                (k < 4) ? 32'(v[7:0]) : 32'hFF);
          end
        end
      end
    end

    // R4 R6 odd-address byte, RAM->periph, fixed address
    ram[12'h100] = 16'h5A3C;
    p0 = plog_n;
    cfg(2, 16'h000F, 12'h201, 12'h0, 10'd1, 8'h40, 4'd15);
    trig(2); trig(2);
    chk("R4 two writes", 32'(plog_n - p0), 2);
    chk("R4 fixed periph addr", 32'(plog_a[(plog_n - 2) % 64]), 32'h40);
    chk("R6 odd lane zero-extended", 32'(pm[8'h40]), 32'h005A);

    // R2 R3 RAM->periph word post-increment
    ram[12'h180] = 16'h1111; ram[12'h181] = 16'h2222; ram[12'h182] = 16'h3333;
    cfg(1, 16'h0003, 12'h300, 12'h0, 10'd2, 8'h41, 4'd15);
    trig(1); trig(1); trig(1);
    for (int k = 0; k < 3; k++)
      chk("R2 RAM to periph data", 32'(plog_d[(plog_n - 3 + k) % 64]), 32'(16'h1111 * (k + 1)));

    // R5 peripheral-supplied address
    pm[8'h44] = 16'hBEEF;
    cfg(4, 16'h0011, 12'h0, 12'h0, 10'd7, 8'h44, 4'd15);
    per_bufaddr_i = 12'h4A2; trig(4);
    per_bufaddr_i = 12'h7F0; trig(4);
    chk("R5 first buffer addr", 32'(ram[11'h251]), 32'hBEEF);
    chk("R5 second buffer addr", 32'(ram[11'h3F8]), 32'hBEEF);

    // R7 simultaneous requests on channels 6, 5, 1
    ram[12'h010] = 16'h7777;
    cfg(6, 16'h002B, 12'h020, 12'h0, 10'd0, 8'h61, 4'd3);
    cfg(5, 16'h002B, 12'h020, 12'h0, 10'd0, 8'h51, 4'd3);
    cfg(1, 16'h002B, 12'h020, 12'h0, 10'd0, 8'h11, 4'd3);
    p0 = plog_n;
    pulse(3, 1);
    chk("R7 three grants", 32'(plog_n - p0), 3);
    chk("R7 order first", 32'(plog_a[p0 % 64]), 32'h11);
    chk("R7 order second", 32'(plog_a[(p0 + 1) % 64]), 32'h51);
    chk("R7 order third", 32'(plog_a[(p0 + 2) % 64]), 32'h61);

    // R8 source selection and disabled channel
    cfg(7, 16'h002B, 12'h020, 12'h0, 10'd0, 8'h71, 4'd9);
    p0 = plog_n; pulse(8, 1);
    chk("R8 unselected source", 32'(plog_n - p0), 0);
    p0 = plog_n; pulse(9, 1);
    chk("R8 selected source", 32'(plog_n - p0), 1);
    chk("R8 selected channel addr", 32'(plog_a[p0 % 64]), 32'h71);
    wr(7, 0, 16'h002A);
    p0 = plog_n; pulse(9, 1);
    chk("R8 disabled ignores", 32'(plog_n - p0), 0);

    // R11 ping-pong
    i0 = irq_cnt[3];
    cfg(3, 16'h0041, 12'h500, 12'h600, 10'd1, 8'h33, 4'd15);
    for (int k = 0; k < 4; k++) begin
      pm[8'h33] = 16'h1000 + 16'(k);
      trig(3);
      if (k == 1) begin rd(3, 6, d); chk("R11 status shows B", 32'(d[1]), 1); end
      if (k == 3) begin rd(3, 6, d); chk("R11 status back to A", 32'(d[1]), 0); end
    end
    chk("R11 A0", 32'(ram[11'h280]), 32'h1000);
    chk("R11 A1", 32'(ram[11'h281]), 32'h1001);
    chk("R11 B0", 32'(ram[11'h300]), 32'h1002);
    chk("R11 B1", 32'(ram[11'h301]), 32'h1003);
    chk("R11 irq per block", 32'(irq_cnt[3] - i0), 2);

    // R10 auto-repeat
    i0 = irq_cnt[0];
    cfg(0, 16'h0021, 12'h700, 12'h0, 10'd0, 8'h30, 4'd12);
    pm[8'h30] = 16'hC001; trig(0);
    chk("R10 first block", 32'(ram[11'h380]), 32'hC001);
    pm[8'h30] = 16'hC002; trig(0);
    chk("R10 restart at base", 32'(ram[11'h380]), 32'hC002);
    chk("R10 no advance", 32'(ram[11'h381]), 32'hFFFF);
    chk("R10 irq each block", 32'(irq_cnt[0] - i0), 2);
    rd(0, 0, d); chk("R10 stays enabled", 32'(d[0]), 1);

    // R12 half-block interrupt, count 4 -> 5 elements, half after 2
    i0 = irq_cnt[2];
    cfg(2, 16'h00A9, 12'h7A0, 12'h0, 10'd4, 8'h32, 4'd15);
    for (int k = 1; k <= 10; k++) begin
      trig(2);
      chk("R12 half irq count", 32'(irq_cnt[2] - i0), 32'((k >= 2) + (k >= 7)));
    end

    // R13 collision: request level held three cycles
    rd(0, 6, d); chk("R13 no collision yet", 32'(d[0]), 0);
    pulse(12, 3);
    rd(0, 6, d); chk("R13 collision set", 32'(d[0]), 1);
    wr(0, 6, 16'h0001);
    rd(0, 6, d); chk("R13 collision cleared", 32'(d[0]), 0);
    pulse(12, 2);
    rd(0, 6, d); chk("R13 granted same cycle", 32'(d[0]), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule